// File: doc/BRIEF.md
# Standby Rail Power-State Controller

This block sequences a platform between fully off and standby. A power-on request turns on the standby-rail enable. The block then waits for the core power-good input. Once that is seen it releases the resume-reset output. It then gives the platform controller a bounded window, counted in millisecond ticks, in which to deassert its suspend-sleep signal. If the window closes first, the block returns to off. In standby, a renewed assertion of suspend-sleep drops the platform back to off.

A force-shutdown request overrides every other transition. It first pulls resume-reset low for one cycle while the rail enable keeps its value. It then removes the rail enable and waits for the sensed well power-good and resume-reset inputs to fall. That wait is bounded by a second millisecond window, and the block declares off when either condition is met. All pins are plain control and status levels with no streaming data, so no valid/ready handshake applies. A 3-bit state code is exported for observation.

Top module: `stby_pwr_ctrl`

## Requirements
- R1: While reset is low, and in the off state (code 0), `rail_en` and `rsm_rst_n` are both 0.
- R2: In off, `pwr_on_req` high at a clock edge moves to rail-up (code 1) with `rail_en`=1 and `rsm_rst_n`=0 after that edge. Without the request the block stays off whatever the other inputs do.
- R3: In rail-up the block waits indefinitely for `core_pg`. The edge that samples `core_pg` high enters the suspend window (code 2) and sets `rsm_rst_n`=1. `rsm_rst_n` never rises unless `rail_en` is high and `core_pg` was high.
- R4: In the suspend window, `sus_sleep_n` high at an edge enters standby (code 3), with both outputs kept high.
- R5: In the suspend window with `sus_sleep_n` low, the block returns to off with both outputs low at the edge that samples the SUS_WIN_MS-th `tick_1ms` pulse since entry. Earlier pulses leave it in the window.
- R6: In standby, `sus_sleep_n` low at an edge returns to off with both outputs low. Ticks alone have no effect in standby.
- R7: `force_off_req` high moves to shutdown-reset (code 4): `rsm_rst_n`=0 and `rail_en` unchanged. The next edge enters shutdown-wait (code 5) with `rail_en`=0.
- R8: In shutdown-wait, the first edge at which `well_pg` and `rsm_sense` are both low moves to off. Either one high keeps the block waiting.
- R9: In shutdown-wait with either sensed input still high, the edge that samples the SHUT_WIN_MS-th tick since entry moves to off.
- R10: `force_off_req` takes priority over every other transition in every state, including off.
- R11: `state_code` shows the state: 0 off, 1 rail-up, 2 suspend window, 3 standby, 4 shutdown-reset, 5 shutdown-wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle strobe every millisecond |
| pwr_on_req | input | 1 | Request to leave off toward standby |
| force_off_req | input | 1 | Forced shutdown request |
| core_pg | input | 1 | Core power-good |
| sus_sleep_n | input | 1 | Suspend-sleep from platform controller, high = deasserted |
| well_pg | input | 1 | Sensed deep-sleep-well power-good |
| rsm_sense | input | 1 | Sensed resume-reset line level |
| rail_en | output | 1 | Standby-rail enable |
| rsm_rst_n | output | 1 | Resume-reset, low holds reset |
| state_code | output | 3 | Current state code |

## Verification
Every result is due one clock edge after the stimulus that causes it. Inputs are changed on the falling edge and sampled at the following falling edge, so exactly one rising edge lies between cause and check. The two windows are swept tick by tick over a small configuration (5 and 3 ms). For each count the expected state is computed as "off once the count equals the window length", and the state is checked after every tick, so an off-by-one in either counter shows on the tick where it occurs. The exits that cut the windows short are also swept at every tick position.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_RAILUP   = 3'd1,
    ST_SUSWAIT  = 3'd2,
    ST_STBY     = 3'd3,
    ST_SHUTRST  = 3'd4,
    ST_SHUTWAIT = 3'd5
  } spc_state_e;
endpackage

// File: rtl/spc_ms_window.sv
module spc_ms_window #(
  parameter int LIMIT = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expired = run && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run)              cnt <= '0;
    else if (tick && !expired)  cnt <= cnt + 1'b1;
  end

  // R5 / R9: the tick count never passes the last step of the window
  assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R5 / R9: idle windows restart from zero
  assert_window_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
endmodule

// File: rtl/stby_pwr_ctrl.sv
module stby_pwr_ctrl
  import spc_pkg::*;
#(
  parameter int SUS_WIN_MS  = 250,
  parameter int SHUT_WIN_MS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1ms,
  input  logic       pwr_on_req,
  input  logic       force_off_req,
  input  logic       core_pg,
  input  logic       sus_sleep_n,
  input  logic       well_pg,
  input  logic       rsm_sense,
  output logic       rail_en,
  output logic       rsm_rst_n,
  output logic [2:0] state_code
);
  spc_state_e state, nxt;
  logic       rail_q, rsm_q;
  logic       sus_exp, shut_exp;

  spc_ms_window #(.LIMIT(SUS_WIN_MS)) u_sus_win (
    .clk(clk), .rst_n(rst_n), .run(state == ST_SUSWAIT),
    .tick(tick_1ms), .expired(sus_exp));

  spc_ms_window #(.LIMIT(SHUT_WIN_MS)) u_shut_win (
    .clk(clk), .rst_n(rst_n), .run(state == ST_SHUTWAIT),
    .tick(tick_1ms), .expired(shut_exp));

  always_comb begin
    nxt = state;
    if (force_off_req) nxt = ST_SHUTRST;
    else begin
      unique case (state)
        ST_OFF:      if (pwr_on_req) nxt = ST_RAILUP;
        ST_RAILUP:   if (core_pg) nxt = ST_SUSWAIT;
        ST_SUSWAIT:  if (sus_sleep_n) nxt = ST_STBY;
                     else if (sus_exp) nxt = ST_OFF;
        ST_STBY:     if (!sus_sleep_n) nxt = ST_OFF;
        ST_SHUTRST:  nxt = ST_SHUTWAIT;
        ST_SHUTWAIT: if ((!well_pg && !rsm_sense) || shut_exp) nxt = ST_OFF;
        default:     nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_OFF;
      rail_q <= 1'b0;
      rsm_q  <= 1'b0;
    end else begin
      state  <= nxt;
      rail_q <= (nxt inside {ST_RAILUP, ST_SUSWAIT, ST_STBY}) ||
                (nxt == ST_SHUTRST && rail_q);
      rsm_q  <= nxt inside {ST_SUSWAIT, ST_STBY};
    end
  end

  assign rail_en    = rail_q;
  assign rsm_rst_n  = rsm_q;
  assign state_code = state;

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_OFF |-> !rail_en && !rsm_rst_n);
  assert_release_after_pg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsm_rst_n) |-> rail_en && $past(core_pg));
  assert_sus_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUSWAIT && sus_sleep_n && !force_off_req) |=> state == ST_STBY);
  assert_stby_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STBY && !sus_sleep_n && !force_off_req) |=> state == ST_OFF);
  assert_reset_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHUTWAIT && $fell(rail_en)) |-> !rsm_rst_n && !$past(rsm_rst_n));
  assert_well_low_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHUTWAIT && !well_pg && !rsm_sense && !force_off_req) |=> state == ST_OFF);
  assert_force_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    force_off_req |=> state == ST_SHUTRST);
endmodule

// File: tb/stby_pwr_ctrl_bench.sv
module stby_pwr_ctrl_bench;
  localparam int SUS  = 5;
  localparam int SHUT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_1ms = 0, pwr_on_req = 0, force_off_req = 0, core_pg = 0;
  logic sus_sleep_n = 0, well_pg = 0, rsm_sense = 0;
  logic rail_en, rsm_rst_n;
  logic [2:0] state_code;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stby_pwr_ctrl #(.SUS_WIN_MS(SUS), .SHUT_WIN_MS(SHUT)) u_stby_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .pwr_on_req(pwr_on_req),
    .force_off_req(force_off_req), .core_pg(core_pg), .sus_sleep_n(sus_sleep_n),
    .well_pg(well_pg), .rsm_sense(rsm_sense), .rail_en(rail_en),
    .rsm_rst_n(rsm_rst_n), .state_code(state_code));

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, int st, bit re, bit rs);
    tests++;
    if (state_code !== 3'(st) || rail_en !== re || rsm_rst_n !== rs) begin
      fails++;
      $display("FAIL %s: got state=%0d rail=%0b rsm=%0b, expected state=%0d rail=%0b rsm=%0b",
               req, state_code, rail_en, rsm_rst_n, st, re, rs);
    end
  endtask

  task automatic pulse_tick();
    tick_1ms = 1; cyc(); tick_1ms = 0;
  endtask

  task automatic to_window();
    pwr_on_req = 1; core_pg = 0; sus_sleep_n = 0; cyc(); pwr_on_req = 0;
    chk("R2", 1, 1, 0);
    core_pg = 1; cyc(); chk("R3", 2, 1, 1);
  endtask

  task automatic to_off();
    well_pg = 0; rsm_sense = 0;
    force_off_req = 1; cyc(); force_off_req = 0; cyc(); cyc();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1", 0, 0, 0);
    rst_n = 1; cyc();
    chk("R1", 0, 0, 0);
    // R2: no request, other inputs toggled
    core_pg = 1; sus_sleep_n = 1; well_pg = 1; rsm_sense = 1; pulse_tick(); cyc();
    chk("R2", 0, 0, 0);
    // R3: rail-up waits without core_pg
    pwr_on_req = 1; core_pg = 0; cyc(); pwr_on_req = 0; chk("R2", 1, 1, 0);
    for (int i = 0; i < 4; i++) begin pulse_tick(); chk("R3", 1, 1, 0); end
    core_pg = 1; cyc(); chk("R3", 2, 1, 1);
    sus_sleep_n = 1; cyc(); chk("R4", 3, 1, 1);
    // R5 sweep: timeout after exactly SUS ticks
    sus_sleep_n = 0; cyc(); chk("R6", 0, 0, 0);
    to_window();
    for (int k = 1; k <= SUS; k++) begin
      pulse_tick();
      if (k == SUS) chk("R5", 0, 0, 0); else chk("R5", 2, 1, 1);
    end
    // R4 sweep: exit after j ticks
    for (int j = 0; j < SUS; j++) begin
      to_window();
      for (int t = 0; t < j; t++) pulse_tick();
      sus_sleep_n = 1; cyc(); chk("R4", 3, 1, 1);
      // R6: ticks do not disturb standby
      pulse_tick(); pulse_tick(); chk("R6", 3, 1, 1);
      sus_sleep_n = 0; cyc(); chk("R6", 0, 0, 0);
    end
    // R7 / R8: forced shutdown from standby
    to_window(); sus_sleep_n = 1; cyc(); chk("R4", 3, 1, 1);
    well_pg = 1; rsm_sense = 1;
    force_off_req = 1; cyc(); force_off_req = 0; chk("R7", 4, 1, 0);
    cyc(); chk("R7", 5, 0, 0);
    well_pg = 0; cyc(); chk("R8", 5, 0, 0);
    well_pg = 1; rsm_sense = 0; cyc(); chk("R8", 5, 0, 0);
    well_pg = 0; cyc(); chk("R8", 0, 0, 0);
    // R9 sweep: shutdown timeout after exactly SHUT ticks
    for (int s = 0; s < 2; s++) begin
      to_window(); sus_sleep_n = 1; cyc();
      well_pg = (s == 0); rsm_sense = (s == 1);
      force_off_req = 1; cyc(); force_off_req = 0; chk("R7", 4, 1, 0);
      cyc(); chk("R11", 5, 0, 0);
      for (int k = 1; k <= SHUT; k++) begin
        pulse_tick();
        if (k == SHUT) chk("R9", 0, 0, 0); else chk("R9", 5, 0, 0);
      end
    end
    // R10: force beats a concurrent suspend exit and a power-on request
    well_pg = 1; rsm_sense = 1;
    to_window(); sus_sleep_n = 1; force_off_req = 1; cyc(); force_off_req = 0;
    chk("R10", 4, 1, 0);
    to_off(); chk("R10", 0, 0, 0);
    pwr_on_req = 1; force_off_req = 1; cyc(); pwr_on_req = 0; force_off_req = 0;
    chk("R10", 4, 0, 0);
    cyc(); chk("R7", 5, 0, 0);
    // R10 in rail-up with core_pg present
    well_pg = 0; rsm_sense = 0; cyc(); chk("R8", 0, 0, 0);
    pwr_on_req = 1; core_pg = 0; cyc(); pwr_on_req = 0;
    core_pg = 1; force_off_req = 1; cyc(); force_off_req = 0;
    chk("R10", 4, 1, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule